// File: doc/BRIEF.md
# Pin-Strobed ADC Conversion Trigger

This block turns a level on a shared device pin into the control strobes of a successive-approximation ADC controller. The pin is synchronized to the core clock. A 3-bit trigger-select field decides whether the pin acts as the conversion strobe at all, and with which polarity. The pin path stays live while the same pin is driven as a timer output, so a timer pulse that loops back through the pad can start conversions.

A mode bit picks one of two timings. In single-edge mode, each sampling edge produces a one-cycle start pulse, and the acquire-enable output is high in that same cycle. In dual-edge mode, the opposite edge first raises acquire-enable so the converter can begin acquiring. The next sampling edge then fires the start pulse and ends acquisition. A sampling edge that arrives while the converter reports busy is dropped.

Top module: `adc_strobe_trig`

## Requirements
- R1: While rst_ni is low, and at its release, acq_en_o and conv_start_o are 0, whatever pin_i does.
- R2: With trig_sel_i = 3'b100, a rising transition of pin_i is a sampling edge. The sampling edge drives conv_start_o high for one cycle, in the third clock cycle after the change of pin_i: two synchronizer stages plus one output register. A falling transition of pin_i produces no start pulse in this setting.
- R3: With trig_sel_i = 3'b101, the pin is inverted, so a falling transition of pin_i is the sampling edge, with the same latency as R2. A rising transition of pin_i produces no start pulse in this setting.
- R4: With dual_edge_i = 0, acq_en_o equals conv_start_o in every cycle.
- R5: With dual_edge_i = 1, the edge opposite to the sampling edge is the acquisition edge. acq_en_o rises in the third cycle after that edge. It stays high up to and including the cycle of the next start pulse, and is low in the cycle after that.
- R6: A sampling edge seen while conv_busy_i is 1 gives no start pulse. In dual-edge mode it still ends acquisition.
- R7: For any trig_sel_i value other than 3'b100 and 3'b101, both outputs stay 0 and the pin is ignored.
- R8: conv_start_o is never high for two consecutive cycles, even when the pin is held at its new level.
- R9: Switching trig_sel_i between 3'b100 and 3'b101 while the pin is steady produces no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw pin level, asynchronous to clk_i |
| trig_sel_i | input | 3 | Trigger source select: 100 = pin as is, 101 = pin inverted |
| dual_edge_i | input | 1 | 0 = single-edge timing, 1 = dual-edge timing |
| conv_busy_i | input | 1 | Converter is busy with a conversion |
| acq_en_o | output | 1 | Acquisition enable level |
| conv_start_o | output | 1 | One-cycle sample-and-start pulse |

## Verification
A stale previous-level register or a wrong polarity mapping shows up as a start pulse on the wrong pin transition, or as no pulse at all. This is visible exactly three cycles after the pin change. A stuck acquisition flag shows up as acq_en_o staying high past the start pulse, or rising in single-edge mode, within one cycle of the sampling edge. A lost busy gate shows up as a start pulse in a busy window, in the same third cycle.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_PIN_DIRECT = 3'b100;
  localparam logic [SEL_W-1:0] SEL_PIN_INVERT = 3'b101;

  typedef struct packed {
    logic samp;  // sampling instant, starts conversion
    logic acq;   // acquisition start (dual-edge mode only)
  } strobe_evt_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/strobe_edge.sv
module strobe_edge
  import adc_trig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              active_o,
  output strobe_evt_t       evt_o
);
  logic lvl_q, rise, fall, direct, invert;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;

  // edges taken on the raw synced pin so a select change makes no false edge
  assign rise   = lvl_i & ~lvl_q;
  assign fall   = ~lvl_i & lvl_q;
  assign direct = (sel_i == SEL_PIN_DIRECT);
  assign invert = (sel_i == SEL_PIN_INVERT);

  assign active_o  = direct | invert;
  assign evt_o.samp = (direct & rise) | (invert & fall);
  assign evt_o.acq  = (direct & fall) | (invert & rise);
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import adc_trig_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        active_i,
  input  strobe_evt_t evt_i,
  input  logic        dual_i,
  input  logic        busy_i,
  output logic        acq_en_o,
  output logic        start_o
);
  logic start_q, acq_q, acq_d;

  assign acq_d = active_i & dual_i & (evt_i.acq | (acq_q & ~evt_i.samp));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      start_q <= 1'b0;
      acq_q   <= 1'b0;
    end else begin
      start_q <= evt_i.samp & ~busy_i;
      acq_q   <= acq_d;
    end

  assign start_o  = start_q;
  assign acq_en_o = acq_q | start_q;
endmodule

// File: rtl/adc_strobe_trig.sv
module adc_strobe_trig
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [SEL_W-1:0] trig_sel_i,
  input  logic             dual_edge_i,
  input  logic             conv_busy_i,
  output logic             acq_en_o,
  output logic             conv_start_o
);
  logic        pin_sync_lvl;
  logic        src_active;
  strobe_evt_t evt;

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync_lvl)
  );

  strobe_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (pin_sync_lvl),
    .sel_i   (trig_sel_i),
    .active_o(src_active),
    .evt_o   (evt)
  );

  trig_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(src_active),
    .evt_i   (evt),
    .dual_i  (dual_edge_i),
    .busy_i  (conv_busy_i),
    .acq_en_o(acq_en_o),
    .start_o (conv_start_o)
  );
endmodule

// File: rtl/adc_strobe_trig_chk.sv
module adc_strobe_trig_chk
  import adc_trig_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] trig_sel_i,
  input logic             dual_edge_i,
  input logic             conv_busy_i,
  input logic             acq_en_o,
  input logic             conv_start_o
);
  logic armed;
  logic sel_idle;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  assign sel_idle = (trig_sel_i != SEL_PIN_DIRECT) && (trig_sel_i != SEL_PIN_INVERT);

  assert_start_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_single_acq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !dual_edge_i && !$past(dual_edge_i)) |-> (acq_en_o == conv_start_o));

  assert_start_has_acq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> acq_en_o);

  assert_busy_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && conv_start_o) |-> !$past(conv_busy_i));

  assert_idle_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(sel_idle)) |-> (!conv_start_o && !acq_en_o));
endmodule

bind adc_strobe_trig adc_strobe_trig_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_sel_i  (trig_sel_i),
  .dual_edge_i (dual_edge_i),
  .conv_busy_i (conv_busy_i),
  .acq_en_o    (acq_en_o),
  .conv_start_o(conv_start_o)
);

// File: tb/adc_strobe_trig_bench.sv
module adc_strobe_trig_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       dual = 1'b0;
  logic       busy = 1'b0;
  logic       acq_en, conv_start;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  adc_strobe_trig u_adc_strobe_trig (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin),
    .trig_sel_i  (sel),
    .dual_edge_i (dual),
    .conv_busy_i (busy),
    .acq_en_o    (acq_en),
    .conv_start_o(conv_start)
  );

  // {sel, dual, busy, pin_from, pin_to, start bits idx6..1, acq bits idx6..1}
  localparam int NV = 11;
  localparam logic [18:0] VECS [NV] = '{
    {3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000100, 6'b000100}, // R2 rise fires, R4
    {3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 6'b000000, 6'b000000}, // R2 fall ignored
    {3'b101, 1'b0, 1'b0, 1'b1, 1'b0, 6'b000100, 6'b000100}, // R3 fall fires
    {3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b000000}, // R3 rise ignored
    {3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 6'b000000, 6'b000000}, // R6 busy
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b000000}, // R7
    {3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 6'b000000, 6'b000000}, // R7
    {3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 6'b000000, 6'b000000}, // R7 dual
    {3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 6'b000000, 6'b111100}, // R5 acq edge
    {3'b101, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b111100}, // R5 inverted acq edge
    {3'b100, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000100, 6'b000100}  // R5 samp without acq
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive pin at a falling edge, then record outputs after each of 6 rising edges
  task automatic toggle_obs(input logic to, output logic [5:0] st, output logic [5:0] aq);
    pin = to;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      st[i] = conv_start;
      aq[i] = acq_en;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] st, aq;
    int hi_cnt;
    // R1 reset state with pin activity and a live select
    sel = 3'b100;
    @(negedge clk); pin = 1'b1;
    @(negedge clk); pin = 1'b0;
    @(negedge clk);
    check(!conv_start && !acq_en, "R1 outputs in reset", {acq_en, conv_start}, 0);
    rst_n = 1'b1;
    check(!conv_start && !acq_en, "R1 outputs at release", {acq_en, conv_start}, 0);
    sel = 3'b000;
    cycles(4);

    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VECS[v];
      sel = 3'b000; dual = 1'b0; busy = 1'b0; pin = e[13];
      cycles(5);
      sel = e[18:16]; dual = e[15]; busy = e[14];
      cycles(3);
      toggle_obs(e[12], st, aq);
      check(st == e[11:6], $sformatf("R2/R3/R6/R7 start vec%0d", v), st, e[11:6]);
      check(aq == e[5:0], $sformatf("R4/R5 acq vec%0d", v), aq, e[5:0]);
    end

    // R5 full dual-edge sequence, direct polarity
    sel = 3'b000; dual = 1'b0; busy = 1'b0; pin = 1'b1; cycles(5);
    sel = 3'b100; dual = 1'b1; cycles(3);
    toggle_obs(1'b0, st, aq);
    check(aq == 6'b111100 && st == 6'b0, "R5 acquire phase", {st, aq}, 12'b000000111100);
    toggle_obs(1'b1, st, aq);
    check(st == 6'b000100, "R5 start after acquire", st, 6'b000100);
    check(aq == 6'b000111, "R5 acq ends after start", aq, 6'b000111);

    // R6 busy in dual mode: no start, acquisition ends
    pin = 1'b1; sel = 3'b000; cycles(5);
    sel = 3'b100; dual = 1'b1; cycles(3);
    toggle_obs(1'b0, st, aq);
    busy = 1'b1;
    toggle_obs(1'b1, st, aq);
    check(st == 6'b0, "R6 dual busy start", st, 0);
    check(aq == 6'b000011, "R6 dual busy acq drop", aq, 6'b000011);
    busy = 1'b0;

    // R9 polarity switch with steady pin
    sel = 3'b000; dual = 1'b0; pin = 1'b1; cycles(5);
    sel = 3'b100; cycles(3);
    hi_cnt = 0;
    sel = 3'b101;
    for (int i = 0; i < 4; i++) begin @(negedge clk); hi_cnt += conv_start; end
    sel = 3'b100;
    for (int i = 0; i < 4; i++) begin @(negedge clk); hi_cnt += conv_start; end
    check(hi_cnt == 0, "R9 select switch no pulse", hi_cnt, 0);

    // R8 held pin: pulse lasts one cycle only
    sel = 3'b000; pin = 1'b0; cycles(5);
    sel = 3'b100; dual = 1'b0; cycles(3);
    pin = 1'b1;
    hi_cnt = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); hi_cnt += conv_start; end
    check(hi_cnt == 1, "R8 one-cycle pulse", hi_cnt, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule